// File: doc/BRIEF.md
# Programmable-Skew Multi-Bank Clock Generator

This block is a cycle-level digital model of the output stage of a multi-phase clock buffer. It is clocked by a fast timing clock whose period is one skew time unit (tU). From a free-running tU counter it derives a reference clock, `base_clk`, and four banks of two outputs each. Each bank decodes a two-digit select code. Each digit is a three-level value, which gives nine codes. Depending on the bank, a code selects a phase offset in whole tU steps, a divide-by-2 or divide-by-4 clock, or an inverted clock.

Four global controls act on all banks. A range select sets how many tU steps make one reference period. An edge select picks whether the outputs align to the rising or the falling reference edge. A test select and an active-low synchronous output enable control when banks stop. A stopped bank freezes at a defined park level, and bank 2 is normally exempt so that it can drive a feedback path.

Each bank runs a gating state machine with four states. In ST_PARKED the output holds the park level. In ST_STARTING the bank has been asked to run and waits for the waveform to reach the park level. In ST_RUN the waveform passes through. In ST_STOPPING the bank has been asked to stop and waits for the waveform to reach the park level. The transitions are:
- PARKED to RUN, or PARKED to STARTING, on a run request. The bank goes straight to RUN if the waveform is already at the park level.
- STARTING to RUN when the waveform reaches the park level. STARTING to PARKED if the request is withdrawn.
- RUN to PARKED, or RUN to STOPPING, on a stop request. The bank goes straight to PARKED if the waveform is already at the park level.
- STOPPING to PARKED when the waveform reaches the park level. STOPPING to RUN if the request returns.

Top module: `skew_clock_banks`

## Requirements
- R1: `range_sel` sets the reference period P: LOW gives 32 tU, MID gives 16 tU and HIGH gives 8 tU. `base_clk` is high for the first P/2 steps of each period and low for the rest.
- R2: Every three-level input is encoded 2'b00 = LOW, 2'b01 = MID and 2'b10 = HIGH, and 2'b11 acts as MID. A bank select is {first digit [3:2], second digit [1:0]}.
- R3: In banks 1 and 2, the codes LL, LM, LH, ML, MM, MH, HL, HM and HH give a 50 % duty clock of period P delayed from `base_clk` by −4, −3, −2, −1, 0, +1, +2, +3 and +4 tU respectively. A negative delay wraps modulo P.
- R4: In bank 3, LL gives divide-by-2 (period 2P) and HH gives divide-by-4 (period 4P). Both rise on a `base_clk` rising edge. The codes LM through HM give delays of −6, −4, −2, 0, +2, +4 and +6 tU.
- R5: In bank 4, LL gives divide-by-2 and HH gives the inverted period-P clock, which rises P/2 after `base_clk` rises. The other codes give the same ±2, ±4 and ±6 tU delays as bank 3.
- R6: With `edge_sel` LOW, every bank output is shifted a further P/2 tU relative to `base_clk`, so it aligns to the falling reference edge. MID and HIGH add no shift.
- R7: With `oe_n` high and `test_sel` not MID, banks 1, 3 and 4 park while bank 2 keeps toggling. A test select of HIGH behaves like LOW.
- R8: A bank 4 output parked while in inverted mode rests HIGH when `edge_sel` is MID or HIGH, and LOW when `edge_sel` is LOW. Every other park level is LOW.
- R9: With `test_sel` MID and `oe_n` high, exactly the banks whose code is LL park, bank 2 included. All other banks keep their selected waveform.
- R10: An output starts and stops only when its waveform already equals the park level, so every high pulse of a running period-P output lasts exactly P/2 tU. No low pulse is shorter than P/2.
- R11: While `rst_n` is low, `base_clk` and all bank outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tu | input | 1 | Timing clock, one period per tU |
| rst_n | input | 1 | Active-low synchronous reset |
| range_sel | input | 2 | Three-level reference period select |
| edge_sel | input | 2 | Three-level alignment edge select |
| test_sel | input | 2 | Three-level test select |
| oe_n | input | 1 | Active-low synchronous output enable |
| sel_b1 | input | 4 | Bank 1 code |
| sel_b2 | input | 4 | Bank 2 code |
| sel_b3 | input | 4 | Bank 3 code |
| sel_b4 | input | 4 | Bank 4 code |
| base_clk | output | 1 | Reference clock, period P |
| q_b1 | output | 2 | Bank 1 outputs |
| q_b2 | output | 2 | Bank 2 outputs |
| q_b3 | output | 2 | Bank 3 outputs |
| q_b4 | output | 2 | Bank 4 outputs |

## Verification
On every cycle, the assertions check three things. First, the tU counter stays inside the selected period and the period index steps only at a wrap. Second, a parked bank shows its park level and a bank enters running without a jump in level. Third, the feedback bank never leaves running unless test mode is active. Only the bench scenarios can show the measured periods, duty and delays for each code, the half-period shift from the edge select, the park levels under each combination of enable and test select, and the absence of runt pulses while the enable toggles repeatedly.

// File: rtl/skew_clk_pkg.sv
package skew_clk_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        WV_SKEW = 2'd0,
        WV_DIV2 = 2'd1,
        WV_DIV4 = 2'd2,
        WV_INV  = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        ST_PARKED   = 2'd0,
        ST_STARTING = 2'd1,
        ST_RUN      = 2'd2,
        ST_STOPPING = 2'd3
    } gate_state_e;

    localparam int KIND_FINE      = 0;
    localparam int KIND_DIV4_END  = 1;
    localparam int KIND_INV_END   = 2;

    function automatic lvl_e decode_lvl(input logic [1:0] raw);
        lvl_e v;
        case (raw)
            2'b00:   v = LVL_LOW;
            2'b10:   v = LVL_HIGH;
            default: v = LVL_MID;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase
    import skew_clk_pkg::*;
#(
    parameter int BASE_STEPS = 32,
    parameter int POS_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lvl_e             range_lvl,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] period_o,
    output logic             base_o
);

    localparam logic [POS_W-1:0] FULL_STEPS = POS_W'(BASE_STEPS);
    localparam logic [POS_W-1:0] ONE        = POS_W'(1);

    logic [POS_W-1:0] period;
    logic [POS_W-1:0] cnt_q;
    logic [1:0]       pidx_q;
    logic             wrap;
    logic             base_q;

    always_comb begin
        unique case (range_lvl)
            LVL_LOW:  period = FULL_STEPS;
            LVL_MID:  period = FULL_STEPS >> 1;
            default:  period = FULL_STEPS >> 2;
        endcase
    end

    assign wrap = (cnt_q >= (period - ONE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pidx_q <= '0;
            base_q <= 1'b0;
        end else begin
            cnt_q  <= wrap ? '0 : (cnt_q + ONE);
            if (wrap) begin
                pidx_q <= pidx_q + 2'd1;
            end
            base_q <= (cnt_q < (period >> 1));
        end
    end

    always_comb begin
        pos_o = cnt_q;
        if (pidx_q[0]) pos_o = pos_o + period;
        if (pidx_q[1]) pos_o = pos_o + (period << 1);
    end

    assign period_o = period;
    assign base_o   = base_q;

    assert_count_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(range_lvl) |-> (cnt_q < period));

    assert_block_index_on_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pidx_q != $past(pidx_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/skew_decode.sv
module skew_decode
    import skew_clk_pkg::*;
#(
    parameter int KIND = KIND_FINE
) (
    input  lvl_e               first_lvl,
    input  lvl_e               second_lvl,
    output wave_e              mode,
    output logic signed [3:0]  skew,
    output logic               is_ll
);

    logic [3:0] idx;
    logic [3:0] rel;

    assign idx   = (4'(first_lvl) * 4'd3) + 4'(second_lvl);
    assign rel   = idx - 4'd4;
    assign is_ll = (idx == 4'd0);

    generate
        if (KIND == KIND_FINE) begin : g_fine
            always_comb begin
                mode = WV_SKEW;
                skew = signed'(rel);
            end
        end else begin : g_coarse
            always_comb begin
                mode = WV_SKEW;
                skew = signed'(rel << 1);
                if (idx == 4'd0) begin
                    mode = WV_DIV2;
                    skew = '0;
                end else if (idx == 4'd8) begin
                    mode = (KIND == KIND_INV_END) ? WV_INV : WV_DIV4;
                    skew = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/skew_bank.sv
module skew_bank
    import skew_clk_pkg::*;
#(
    parameter int KIND            = KIND_FINE,
    parameter bit FEEDBACK_EXEMPT = 1'b0,
    parameter int POS_W           = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] period,
    input  lvl_e             edge_lvl,
    input  lvl_e             test_lvl,
    input  logic             oe_n,
    input  logic [3:0]       sel,
    output logic [1:0]       q
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    wave_e             mode;
    logic signed [3:0] skew;
    logic              is_ll;
    logic [POS_W-1:0]  hoff;
    logic [POS_W-1:0]  skew_w;
    logic [POS_W-1:0]  ls;
    logic              div1, div2, div4;
    logic              raw;
    logic              park_lvl;
    logic              want;
    logic              at_park;
    gate_state_e       state_q, state_d;
    logic              q_r;

    skew_decode #(.KIND(KIND)) u_decode (
        .first_lvl  (decode_lvl(sel[3:2])),
        .second_lvl (decode_lvl(sel[1:0])),
        .mode       (mode),
        .skew       (skew),
        .is_ll      (is_ll)
    );

    // Phase position of this bank inside the four-period window.
    always_comb begin
        hoff   = (edge_lvl == LVL_LOW) ? (period >> 1) : '0;
        skew_w = {{(POS_W-4){skew[3]}}, skew};
        ls     = (pos - hoff - skew_w) & ((period << 2) - ONE);
        div1   = (ls & (period - ONE)) < (period >> 1);
        div2   = (ls & ((period << 1) - ONE)) < period;
        div4   = ls < (period << 1);
    end

    always_comb begin
        unique case (mode)
            WV_SKEW: raw = div1;
            WV_DIV2: raw = div2;
            WV_DIV4: raw = div4;
            default: raw = ~div1;
        endcase
    end

    assign park_lvl = (mode == WV_INV) && (edge_lvl != LVL_LOW);
    assign at_park  = (raw == park_lvl);

    always_comb begin
        if (!oe_n) begin
            want = 1'b1;
        end else if (test_lvl == LVL_MID) begin
            want = !is_ll;
        end else begin
            want = FEEDBACK_EXEMPT;
        end
    end

    // Next-state logic of the gating machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARKED:   if (want) state_d = at_park ? ST_RUN : ST_STARTING;
            ST_STARTING: if (!want) state_d = ST_PARKED;
                         else if (at_park) state_d = ST_RUN;
            ST_RUN:      if (!want) state_d = at_park ? ST_PARKED : ST_STOPPING;
            ST_STOPPING: if (want) state_d = ST_RUN;
                         else if (at_park) state_d = ST_PARKED;
            default:     state_d = ST_PARKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PARKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: waveform while running, park level otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            q_r <= (state_d == ST_RUN || state_d == ST_STOPPING) ? raw : park_lvl;
        end
    end

    assign q = {q_r, q_r};

    assert_parked_at_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == ST_PARKED && $stable(edge_lvl) && $stable(sel))
        |-> (q_r == park_lvl));

    assert_run_entry_no_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == ST_RUN &&
         ($past(state_q) == ST_PARKED || $past(state_q) == ST_STARTING) &&
         $stable(edge_lvl) && $stable(sel))
        |-> (q_r == park_lvl));

    generate
        if (FEEDBACK_EXEMPT) begin : g_fb_check
            assert_feedback_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(test_lvl) != LVL_MID && $past(state_q) == ST_RUN)
                |-> (state_q == ST_RUN));
        end
    endgenerate

endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
    import skew_clk_pkg::*;
#(
    parameter int BASE_STEPS = 32
) (
    input  logic       clk_tu,
    input  logic       rst_n,
    input  logic [1:0] range_sel,
    input  logic [1:0] edge_sel,
    input  logic [1:0] test_sel,
    input  logic       oe_n,
    input  logic [3:0] sel_b1,
    input  logic [3:0] sel_b2,
    input  logic [3:0] sel_b3,
    input  logic [3:0] sel_b4,
    output logic       base_clk,
    output logic [1:0] q_b1,
    output logic [1:0] q_b2,
    output logic [1:0] q_b3,
    output logic [1:0] q_b4
);

    localparam int POS_W   = $clog2(BASE_STEPS) + 2;
    localparam int N_BANKS = 4;
    localparam int BANK_KIND [N_BANKS] = '{KIND_FINE, KIND_FINE, KIND_DIV4_END, KIND_INV_END};
    localparam int FB_BANK = 1;

    lvl_e             range_lvl, edge_lvl, test_lvl;
    logic [POS_W-1:0] pos, period;
    logic [3:0]       sel_a [N_BANKS];
    logic [1:0]       q_a   [N_BANKS];

    assign range_lvl = decode_lvl(range_sel);
    assign edge_lvl  = decode_lvl(edge_sel);
    assign test_lvl  = decode_lvl(test_sel);

    assign sel_a[0] = sel_b1;
    assign sel_a[1] = sel_b2;
    assign sel_a[2] = sel_b3;
    assign sel_a[3] = sel_b4;

    skew_timebase #(.BASE_STEPS(BASE_STEPS), .POS_W(POS_W)) u_timebase (
        .clk       (clk_tu),
        .rst_n     (rst_n),
        .range_lvl (range_lvl),
        .pos_o     (pos),
        .period_o  (period),
        .base_o    (base_clk)
    );

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            skew_bank #(
                .KIND            (BANK_KIND[b]),
                .FEEDBACK_EXEMPT (b == FB_BANK),
                .POS_W           (POS_W)
            ) u_bank (
                .clk      (clk_tu),
                .rst_n    (rst_n),
                .pos      (pos),
                .period   (period),
                .edge_lvl (edge_lvl),
                .test_lvl (test_lvl),
                .oe_n     (oe_n),
                .sel      (sel_a[b]),
                .q        (q_a[b])
            );
        end
    endgenerate

    assign q_b1 = q_a[0];
    assign q_b2 = q_a[1];
    assign q_b3 = q_a[2];
    assign q_b4 = q_a[3];

endmodule

// File: tb/skew_clock_banks_bench.sv
module skew_clock_banks_bench;

    localparam logic [1:0] L = 2'b00, M = 2'b01, H = 2'b10;

    typedef struct packed {
        int bank; int a; int b; int rng; int edg; int kind; int skew;
    } row_t;

    // kind: 0 phase step, 1 divide-by-2, 2 divide-by-4, 3 inverted
    localparam row_t ROWS [14] = '{
        '{1, 0, 0, 0, 2, 0, -4},
        '{1, 2, 2, 1, 2, 0,  4},
        '{2, 0, 1, 2, 2, 0, -3},
        '{2, 3, 3, 1, 1, 0,  0},
        '{3, 0, 0, 0, 2, 1,  0},
        '{3, 2, 2, 2, 2, 2,  0},
        '{3, 0, 1, 1, 2, 0, -6},
        '{3, 2, 1, 0, 2, 0,  6},
        '{4, 2, 2, 1, 2, 3,  0},
        '{4, 0, 0, 2, 2, 1,  0},
        '{4, 1, 0, 0, 0, 0, -2},
        '{1, 1, 2, 2, 0, 0,  1},
        '{4, 2, 2, 2, 0, 3,  0},
        '{3, 2, 0, 1, 3, 0,  4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] range_sel = L, edge_sel = H, test_sel = L;
    logic       oe_n = 1'b0;
    logic [3:0] sel_b1 = 4'b0101, sel_b2 = 4'b0101, sel_b3 = 4'b0101, sel_b4 = 4'b0101;
    logic       base_clk;
    logic [1:0] q_b1, q_b2, q_b3, q_b4;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    skew_clock_banks u_skew_clock_banks (
        .clk_tu(clk), .rst_n(rst_n), .range_sel(range_sel), .edge_sel(edge_sel),
        .test_sel(test_sel), .oe_n(oe_n), .sel_b1(sel_b1), .sel_b2(sel_b2),
        .sel_b3(sel_b3), .sel_b4(sel_b4), .base_clk(base_clk),
        .q_b1(q_b1), .q_b2(q_b2), .q_b3(q_b3), .q_b4(q_b4)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic pick(input int ch);
        case (ch)
            0: return base_clk;
            1: return q_b1[0];
            2: return q_b2[0];
            3: return q_b3[0];
            default: return q_b4[0];
        endcase
    endfunction

    function automatic int period_of(input int rng);
        case (rng)
            0: return 32;
            2: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Period, high time and delay from the latest base_clk rise.
    task automatic measure(input int ch, output int per, output int hi, output int off);
        int t, last_base, r1, r2, f1;
        logic pb, pc, cb, cc;
        t = 0; last_base = -1; r1 = -1; r2 = -1; f1 = -1; off = -1;
        @(negedge clk);
        pb = base_clk; pc = pick(ch);
        while (r2 < 0 && t < 700) begin
            @(negedge clk);
            t++;
            cb = base_clk; cc = pick(ch);
            if (cb && !pb) last_base = t;
            if (cc && !pc) begin
                if (r1 >= 0) r2 = t;
                else if (last_base >= 0) begin r1 = t; off = t - last_base; end
            end
            if (!cc && pc && r1 >= 0 && f1 < 0) f1 = t;
            pb = cb; pc = cc;
        end
        per = (r2 >= 0) ? r2 - r1 : -1;
        hi  = (f1 >= 0) ? f1 - r1 : -1;
    endtask

    task automatic scan(input int ch, input int n, output int toggles, output logic lvl);
        logic prev;
        toggles = 0;
        @(negedge clk);
        prev = pick(ch);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pick(ch) != prev) toggles++;
            prev = pick(ch);
        end
        lvl = prev;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int per, hi, off, tg, p, hoff, eper, eoff;
        logic lv;
        string tag;

        // R11: reset state
        settle(6);
        chk(base_clk == 1'b0, "R11", "base_clk in reset", base_clk, 0);
        chk(q_b1 == 2'b00, "R11", "q_b1 in reset", q_b1, 0);
        chk(q_b2 == 2'b00, "R11", "q_b2 in reset", q_b2, 0);
        chk(q_b3 == 2'b00, "R11", "q_b3 in reset", q_b3, 0);
        chk(q_b4 == 2'b00, "R11", "q_b4 in reset", q_b4, 0);
        rst_n = 1'b1;

        // R1: reference period per range
        for (int r = 0; r < 3; r++) begin
            range_sel = 2'(r);
            settle(100);
            measure(0, per, hi, off);
            chk(per == period_of(r), "R1", "base period", per, period_of(r));
            chk(hi == period_of(r) / 2, "R1", "base high time", hi, period_of(r) / 2);
        end

        // R2..R6: vector table
        foreach (ROWS[i]) begin
            sel_b1 = 4'b0101; sel_b2 = 4'b0101; sel_b3 = 4'b0101; sel_b4 = 4'b0101;
            case (ROWS[i].bank)
                1: sel_b1 = {2'(ROWS[i].a), 2'(ROWS[i].b)};
                2: sel_b2 = {2'(ROWS[i].a), 2'(ROWS[i].b)};
                3: sel_b3 = {2'(ROWS[i].a), 2'(ROWS[i].b)};
                default: sel_b4 = {2'(ROWS[i].a), 2'(ROWS[i].b)};
            endcase
            range_sel = 2'(ROWS[i].rng);
            edge_sel  = 2'(ROWS[i].edg);
            settle(300);
            measure(ROWS[i].bank, per, hi, off);
            p    = period_of(ROWS[i].rng);
            hoff = (ROWS[i].edg == 0) ? p / 2 : 0;
            case (ROWS[i].kind)
                1: begin eper = 2 * p; eoff = hoff; end
                2: begin eper = 4 * p; eoff = hoff; end
                3: begin eper = p; eoff = (p / 2 + hoff) % p; end
                default: begin eper = p; eoff = (((ROWS[i].skew + hoff) % p) + p) % p; end
            endcase
            tag = (ROWS[i].bank <= 2) ? "R3" : ((ROWS[i].bank == 3) ? "R4" : "R5");
            if (ROWS[i].edg == 0) tag = {tag, "/R6"};
            if (ROWS[i].a == 3 || ROWS[i].edg == 3) tag = {tag, "/R2"};
            chk(per == eper, tag, $sformatf("row %0d period", i), per, eper);
            chk(hi == eper / 2, tag, $sformatf("row %0d high time", i), hi, eper / 2);
            chk(off == eoff, tag, $sformatf("row %0d delay", i), off, eoff);
        end

        // R7: enable deasserted, bank 2 keeps running
        sel_b1 = 4'b0101; sel_b2 = 4'b0101; sel_b3 = 4'b0101; sel_b4 = 4'b0101;
        range_sel = H; edge_sel = H; test_sel = L; oe_n = 1'b1;
        settle(40);
        scan(1, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R7", "bank1 parked low", tg, 0);
        scan(2, 64, tg, lv); chk(tg > 0, "R7", "bank2 toggles", tg, 16);
        scan(3, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R7", "bank3 parked low", tg, 0);
        scan(4, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R7", "bank4 parked low", tg, 0);
        test_sel = H;
        settle(40);
        scan(1, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R7", "test HIGH bank1 parked", tg, 0);
        scan(2, 64, tg, lv); chk(tg > 0, "R7", "test HIGH bank2 toggles", tg, 16);
        test_sel = L;

        // R8: inverted bank 4 park level
        sel_b4 = {H, H}; edge_sel = H;
        settle(40);
        scan(4, 64, tg, lv); chk(tg == 0 && lv == 1'b1, "R8", "inverted park, edge HIGH", lv, 1);
        edge_sel = M;
        settle(40);
        scan(4, 64, tg, lv); chk(tg == 0 && lv == 1'b1, "R8", "inverted park, edge MID", lv, 1);
        edge_sel = L;
        settle(40);
        scan(4, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R8", "inverted park, edge LOW", lv, 0);

        // R9: test MID disables only LL banks
        edge_sel = H; test_sel = M;
        sel_b1 = {L, L}; sel_b2 = {L, L}; sel_b3 = {M, M}; sel_b4 = {H, M};
        settle(60);
        scan(1, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R9", "bank1 LL parked", tg, 0);
        scan(2, 64, tg, lv); chk(tg == 0 && lv == 1'b0, "R9", "bank2 LL parked", tg, 0);
        measure(3, per, hi, off);
        chk(per == 8 && off == 0, "R9", "bank3 keeps zero delay", off, 0);
        measure(4, per, hi, off);
        chk(per == 8 && off == 6, "R9", "bank4 keeps +6 delay", off, 6);

        // R10: repeated enable toggling leaves no runt pulses
        test_sel = L; oe_n = 1'b0;
        sel_b1 = 4'b0101; sel_b2 = 4'b0101; sel_b3 = 4'b0101; sel_b4 = 4'b0101;
        settle(40);
        begin
            int bad, pulses, rise_t, fall_t;
            logic pv, cv;
            bad = 0; pulses = 0; rise_t = -1; fall_t = -1;
            @(negedge clk);
            pv = q_b1[0];
            for (int i = 0; i < 700; i++) begin
                oe_n = ((i / 13) % 2) == 1;
                @(negedge clk);
                cv = q_b1[0];
                if (cv && !pv) begin
                    if (fall_t >= 0 && (i - fall_t) < 4) bad++;
                    rise_t = i;
                end
                if (!cv && pv) begin
                    if (rise_t >= 0) begin
                        pulses++;
                        if ((i - rise_t) != 4) bad++;
                    end
                    fall_t = i;
                end
                pv = cv;
            end
            chk(bad == 0, "R10", "runt pulses on bank1", bad, 0);
            chk(pulses > 10, "R10", "bank1 resumed pulses", pulses, 44);
        end

        finish_run();
    end

endmodule